// File: doc/BRIEF.md
# Nibble-Wide Two-Phase Processor Core

This block is a very small processor with a 4-bit data path. It runs programs of up to 64 twelve-bit instruction words. The words are held in an on-chip program store that a simple synchronous write port fills while the core sits in reset. Each instruction takes two clock cycles. In the first cycle the word at the program counter is latched. In the second cycle the operands are read, the result is written back, the status flags change and the program counter moves on.

The core has sixteen 4-bit registers. Register 0 is not a general register. It shows the status flags as {0, less, zero, carry}, and only its carry bit can be written. Arithmetic and shift instructions always take the current carry as their carry-in, borrow-in or shift-in bit. The core has no memory of its own. Data storage and peripherals sit on an external nibble bus, which is addressed indirectly through a register and strobed during the execute cycle of the two transfer instructions.

The reset input is asynchronous and active low. Its release is synchronised inside the core, so execution starts on the third rising edge after the input goes high.

Top module: `nib_cpu`

## Requirements
- R1: Instructions alternate between a fetch cycle and an execute cycle. The program counter changes only at the end of an execute cycle, so it holds each value for two clocks.
- R2: The opcode is in instruction bits 3:0. Register A (destination and first source) is in bits 7:4. Register B or the 4-bit immediate is in bits 11:8. Opcodes: 0 ADD, 1 SUB, 2 AND, 3 OR, 4 NOT, 5 XOR, 6 SHL, 7 SHR, 8 CMP, 9 LDI, A MOV, B IN, C OUT, D branch group. Opcodes E and F change nothing except advancing the program counter.
- R3: ADD computes A+B+carry. SUB computes A−B−carry. Both write the 4-bit result to A and the carry-out (or borrow) to the carry flag. SUB also sets less to (A < B, unsigned).
- R4: SHL writes {A[2:0], carry} to A and moves A[3] into carry. SHR writes {carry, A[3:1]} to A and moves A[0] into carry.
- R5: AND, OR, XOR and NOT (NOT gives ~A) write A and leave carry and less unchanged. Every operation from opcode 0 to 8 sets zero when its result is 0.
- R6: CMP sets zero to (A == B) and less to (A < B, unsigned). It writes no register and leaves carry unchanged.
- R7: LDI writes the immediate to A. MOV copies the value of B to A. Reading register 0 returns {0, less, zero, carry}. Writing register 0 sets only the carry flag, from bit 0, and this takes precedence over a carry update from the same instruction.
- R8: The bus strobe is high only during the execute cycle of IN (direction 0) or OUT (direction 1). The address is the value of register B. OUT drives the value of register A as write data. IN writes the returned nibble into A.
- R9: For opcode D, bits 9:4 give an absolute target and bits 11:10 select the branch: 0 always jumps, 1 jumps when zero is clear, 2 jumps when less is set, 3 never jumps. When the branch is not taken, the program counter increments.
- R10: The program counter increments by one after every non-branch instruction and wraps from 63 to 0.
- R11: While reset is low, the strobe is low and the program counter is 0. Reset clears all registers and flags. Program memory written through the load port keeps its contents across reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pm_we | input | 1 | Program store write enable |
| pm_waddr | input | 6 | Program store write address |
| pm_wdata | input | 12 | Program store write word |
| pc | output | 6 | Current program counter |
| bus_stb | output | 1 | Bus transfer strobe, high for one execute cycle |
| bus_dir | output | 1 | Bus direction: 1 write, 0 read |
| bus_addr | output | 4 | Bus address (value of register B) |
| bus_wdata | output | 4 | Bus write data (value of register A) |
| bus_rdata | input | 4 | Bus read data, sampled at the end of the execute cycle |

## Verification
The status register is the hardest state to reach from the ports. It is only visible when a program copies register 0 into a general register, or uses it as an operand, and then sends the result out over the bus. Its value also depends on the exact order of the carry, zero and less updates. The stimulus programs therefore chain carry-consuming instructions and snapshot register 0 with MOV and OUT after a borrowing subtract and after a compare. They then reload the carry through an immediate write to register 0 and read a written value back with IN. A second program drives a counted JNZ loop, JLS both taken and not taken, and a jump to the last two words so that the counter wraps. A third program runs after a reset, with no reload of the program store, to show that registers and flags came back cleared.

// File: rtl/nib_pkg.sv
package nib_pkg;

  localparam int NIB_DW   = 4;
  localparam int NIB_NREG = 16;
  localparam int NIB_PCW  = 6;
  localparam int NIB_OPW  = 4;
  localparam int NIB_IW   = 12;

  typedef enum logic [3:0] {
    OP_ADD = 4'h0, OP_SUB = 4'h1, OP_AND = 4'h2, OP_OR  = 4'h3,
    OP_NOT = 4'h4, OP_XOR = 4'h5, OP_SHL = 4'h6, OP_SHR = 4'h7,
    OP_CMP = 4'h8, OP_LDI = 4'h9, OP_MOV = 4'hA, OP_IN  = 4'hB,
    OP_OUT = 4'hC, OP_BR  = 4'hD, OP_NPE = 4'hE, OP_NPF = 4'hF
  } op_e;

  typedef enum logic [1:0] {
    BR_ALWAYS = 2'd0, BR_NZ = 2'd1, BR_LT = 2'd2, BR_NEVER = 2'd3
  } br_e;

  typedef enum logic {PH_FETCH = 1'b0, PH_EXEC = 1'b1} phase_e;

  typedef struct packed {
    logic less;
    logic zero;
    logic carry;
  } flags_t;

endpackage

// File: rtl/nib_pmem.sv
module nib_pmem #(
  parameter int AW = 6,
  parameter int IW = 12
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [IW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [IW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [IW-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      words[waddr] <= wdata;
    end
  end

  assign rdata = words[raddr];
endmodule

// File: rtl/nib_seq.sv
module nib_seq
  import nib_pkg::*;
#(
  parameter int PCW = 6,
  parameter int IW  = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [IW-1:0]  word_in,
  input  logic           jump,
  input  logic [PCW-1:0] target,
  output phase_e         phase,
  output logic [PCW-1:0] pc,
  output logic [IW-1:0]  ir
);
  phase_e         phase_d;
  logic [PCW-1:0] pc_d;
  logic           pc_en;
  logic           ir_en;

  always_comb begin
    ir_en   = (phase == PH_FETCH);
    pc_en   = (phase == PH_EXEC);
    phase_d = (phase == PH_FETCH) ? PH_EXEC : PH_FETCH;
    pc_d    = jump ? target : PCW'(pc + 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_FETCH;
      pc    <= '0;
      ir    <= '0;
    end else begin
      phase <= phase_d;
      if (pc_en) pc <= pc_d;
      if (ir_en) ir <= word_in;
    end
  end

  assert_fetch_holds_pc_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FETCH) |=> $stable(pc));

  assert_phase_alternates_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FETCH) |=> (phase == PH_EXEC));
endmodule

// File: rtl/nib_alu.sv
module nib_alu
  import nib_pkg::*;
#(
  parameter int DW = 4
) (
  input  op_e           op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  output logic [DW-1:0] res,
  output logic          cout,
  output logic          c_upd,
  output logic          z_upd,
  output logic          l_upd,
  output logic          zero,
  output logic          less
);
  logic [DW:0] sum;
  logic [DW:0] diff;
  logic [DW:0] cmpd;

  always_comb begin
    sum  = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
    diff = {1'b0, a} - {1'b0, b} - {{DW{1'b0}}, cin};
    cmpd = {1'b0, a} - {1'b0, b};
    res   = '0;
    cout  = 1'b0;
    c_upd = 1'b0;
    l_upd = 1'b0;
    z_upd = (op <= OP_CMP);
    less  = cmpd[DW];
    unique case (op)
      OP_ADD: begin res = sum[DW-1:0];  cout = sum[DW];  c_upd = 1'b1; end
      OP_SUB: begin res = diff[DW-1:0]; cout = diff[DW]; c_upd = 1'b1; l_upd = 1'b1; end
      OP_AND: res = a & b;
      OP_OR:  res = a | b;
      OP_NOT: res = ~a;
      OP_XOR: res = a ^ b;
      OP_SHL: begin res = {a[DW-2:0], cin}; cout = a[DW-1]; c_upd = 1'b1; end
      OP_SHR: begin res = {cin, a[DW-1:1]}; cout = a[0];    c_upd = 1'b1; end
      OP_CMP: begin res = cmpd[DW-1:0]; l_upd = 1'b1; end
      default: res = '0;
    endcase
    zero = (res == '0);
  end
endmodule

// File: rtl/nib_regfile.sv
module nib_regfile
  import nib_pkg::*;
#(
  parameter int DW   = 4,
  parameter int NREG = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [$clog2(NREG)-1:0] ra_idx,
  input  logic [$clog2(NREG)-1:0] rb_idx,
  output logic [DW-1:0]           ra_val,
  output logic [DW-1:0]           rb_val,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] wa,
  input  logic [DW-1:0]           wd,
  input  logic                    c_upd,
  input  logic                    c_val,
  input  logic                    z_upd,
  input  logic                    z_val,
  input  logic                    l_upd,
  input  logic                    l_val,
  output flags_t                  flags
);
  localparam int RAW = $clog2(NREG);

  logic [DW-1:0] regs [NREG];
  flags_t        flags_d;
  logic          r0_wr;

  always_comb begin
    regs[0] = {{(DW-3){1'b0}}, flags.less, flags.zero, flags.carry};
    r0_wr   = we && (wa == '0);
    flags_d = flags;
    if (z_upd) flags_d.zero = z_val;
    if (l_upd) flags_d.less = l_val;
    if (r0_wr)      flags_d.carry = wd[0];
    else if (c_upd) flags_d.carry = c_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= flags_d;
  end

  for (genvar gi = 1; gi < NREG; gi++) begin : g_reg
    logic en;
    assign en = we && (wa == RAW'(gi));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  regs[gi] <= '0;
      else if (en) regs[gi] <= wd;
    end
  end

  assign ra_val = regs[ra_idx];
  assign rb_val = regs[rb_idx];

  assert_r0_write_sets_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    r0_wr |=> (flags.carry == $past(wd[0])));
endmodule

// File: rtl/nib_cpu.sv
module nib_cpu
  import nib_pkg::*;
#(
  parameter int DW   = NIB_DW,
  parameter int NREG = NIB_NREG,
  parameter int PCW  = NIB_PCW,
  parameter int IW   = NIB_IW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pm_we,
  input  logic [PCW-1:0] pm_waddr,
  input  logic [IW-1:0]  pm_wdata,
  output logic [PCW-1:0] pc,
  output logic           bus_stb,
  output logic           bus_dir,
  output logic [DW-1:0]  bus_addr,
  output logic [DW-1:0]  bus_wdata,
  input  logic [DW-1:0]  bus_rdata
);
  localparam int RAW = $clog2(NREG);
  localparam int OPW = NIB_OPW;

  logic           sync1, core_rst_n;
  logic [IW-1:0]  word, ir;
  phase_e         phase;
  op_e            op;
  br_e            bsel;
  logic [RAW-1:0] fa, fb;
  logic [DW-1:0]  imm, ra_val, rb_val;
  logic [PCW-1:0] tgt;
  logic           exec, jump, wr_en;
  flags_t         flags;
  logic [DW-1:0]  alu_res, mux_mv, mux_io, wb_val;
  logic           alu_c, alu_cu, alu_zu, alu_lu, alu_z, alu_l;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1      <= 1'b0;
      core_rst_n <= 1'b0;
    end else begin
      sync1      <= 1'b1;
      core_rst_n <= sync1;
    end
  end

  nib_pmem #(.AW(PCW), .IW(IW)) u_pmem (
    .clk(clk), .we(pm_we), .waddr(pm_waddr), .wdata(pm_wdata),
    .raddr(pc), .rdata(word)
  );

  nib_seq #(.PCW(PCW), .IW(IW)) u_seq (
    .clk(clk), .rst_n(core_rst_n), .word_in(word), .jump(jump),
    .target(tgt), .phase(phase), .pc(pc), .ir(ir)
  );

  always_comb begin
    op   = op_e'(ir[OPW-1:0]);
    fa   = ir[OPW +: RAW];
    fb   = ir[OPW+RAW +: RAW];
    imm  = ir[OPW+RAW +: DW];
    tgt  = ir[OPW +: PCW];
    bsel = br_e'(ir[IW-1 -: 2]);
    exec = (phase == PH_EXEC);
    unique case (bsel)
      BR_ALWAYS: jump = 1'b1;
      BR_NZ:     jump = !flags.zero;
      BR_LT:     jump = flags.less;
      default:   jump = 1'b0;
    endcase
    jump  = jump && exec && (op == OP_BR);
    wr_en = exec && ((op <= OP_SHR) || (op == OP_LDI) ||
                     (op == OP_MOV) || (op == OP_IN));
  end

  nib_alu #(.DW(DW)) u_alu (
    .op(op), .a(ra_val), .b(rb_val), .cin(flags.carry),
    .res(alu_res), .cout(alu_c), .c_upd(alu_cu), .z_upd(alu_zu),
    .l_upd(alu_lu), .zero(alu_z), .less(alu_l)
  );

  // write-back selection: move/ALU, then bus read, then immediate
  always_comb begin
    mux_mv = (op == OP_MOV) ? rb_val    : alu_res;
    mux_io = (op == OP_IN)  ? bus_rdata : mux_mv;
    wb_val = (op == OP_LDI) ? imm       : mux_io;
  end

  nib_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk(clk), .rst_n(core_rst_n), .ra_idx(fa), .rb_idx(fb),
    .ra_val(ra_val), .rb_val(rb_val),
    .we(wr_en), .wa(fa), .wd(wb_val),
    .c_upd(exec && alu_cu), .c_val(alu_c),
    .z_upd(exec && alu_zu), .z_val(alu_z),
    .l_upd(exec && alu_lu), .l_val(alu_l),
    .flags(flags)
  );

  assign bus_stb   = exec && ((op == OP_IN) || (op == OP_OUT));
  assign bus_dir   = exec && (op == OP_OUT);
  assign bus_addr  = rb_val;
  assign bus_wdata = ra_val;

  assert_strobe_in_exec_R8: assert property (@(posedge clk) disable iff (!core_rst_n)
    bus_stb |-> (phase == PH_EXEC));

  assert_pc_steps_R10: assert property (@(posedge clk) disable iff (!core_rst_n)
    (exec && (op != OP_BR)) |=> (pc == PCW'($past(pc) + 1'b1)));

  assert_jmp_lands_R9: assert property (@(posedge clk) disable iff (!core_rst_n)
    (exec && (op == OP_BR) && (bsel == BR_ALWAYS)) |=> (pc == $past(tgt)));

  assert_cmp_no_write_R6: assert property (@(posedge clk) disable iff (!core_rst_n)
    (exec && (op == OP_CMP)) |-> !wr_en);

  assert_reset_idle_R11: assert property (@(posedge clk)
    !rst_n |-> (!bus_stb && (pc == '0)));
endmodule

// File: tb/sim_nib_cpu.sv
module sim_nib_cpu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pm_we = 1'b0;
  logic [5:0]  pm_waddr = '0;
  logic [11:0] pm_wdata = '0;
  logic [5:0]  pc;
  logic        bus_stb, bus_dir;
  logic [3:0]  bus_addr, bus_wdata, bus_rdata;

  always #5 clk = ~clk;

  nib_cpu u0 (
    .clk(clk), .rst_n(rst_n), .pm_we(pm_we), .pm_waddr(pm_waddr),
    .pm_wdata(pm_wdata), .pc(pc), .bus_stb(bus_stb), .bus_dir(bus_dir),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  // peripheral nibble memory and its fill port
  logic [3:0] periph [16];
  logic       fill_en = 1'b0;
  logic [3:0] fill_a = '0, fill_d = '0;
  assign bus_rdata = periph[bus_addr];
  always @(posedge clk) begin
    if (fill_en) periph[fill_a] <= fill_d;
    else if (bus_stb && bus_dir) periph[bus_addr] <= bus_wdata;
  end

  // reference model
  logic [11:0] prog [64];
  int mr [16];
  int mmem [16];
  int mc, mz, ml, mpc, mph, msync;
  logic [11:0] mir;
  int n_chk = 0, n_fail = 0, c_chk = 0, c_fail = 0;
  bit done = 1'b0;

  function automatic int rdv(input int i);
    return (i == 0) ? (ml * 4 + mz * 2 + mc) : mr[i];
  endfunction

  task automatic model_exec();
    int op, a, b, va, vb, s, res, sel, tgt;
    bit wr, take;
    op = int'(mir[3:0]); a = int'(mir[7:4]); b = int'(mir[11:8]);
    va = rdv(a); vb = rdv(b); res = 0; wr = 1'b0;
    sel = int'(mir[11:10]); tgt = int'(mir[9:4]); take = 1'b0;
    case (op)
      0: begin s = va + vb + mc; res = s % 16; mc = (s > 15); wr = 1; end
      1: begin s = va - vb - mc; res = (s + 32) % 16; mc = (s < 0); ml = (va < vb); wr = 1; end
      2: begin res = va & vb; wr = 1; end
      3: begin res = va | vb; wr = 1; end
      4: begin res = 15 - va; wr = 1; end
      5: begin res = va ^ vb; wr = 1; end
      6: begin res = ((va * 2) + mc) % 16; mc = va / 8; wr = 1; end
      7: begin res = (va / 2) + mc * 8; mc = va % 2; wr = 1; end
      8: begin res = (va - vb + 16) % 16; ml = (va < vb); end
      9: begin res = b; wr = 1; end
      10: begin res = vb; wr = 1; end
      11: begin res = mmem[vb]; wr = 1; end
      12: mmem[vb] = va;
      13: take = (sel == 0) || (sel == 1 && mz == 0) || (sel == 2 && ml == 1);
      default: ;
    endcase
    if (op <= 8) mz = (res == 0);
    if (wr) begin
      if (a == 0) mc = res % 2;
      else        mr[a] = res;
    end
    mpc = take ? tgt : (mpc + 1) % 64;
  endtask

  always @(posedge clk) begin
    if (fill_en) mmem[fill_a] = int'(fill_d);
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mr[i] = 0;
      mc = 0; mz = 0; ml = 0; mpc = 0; mph = 0; msync = 0; mir = '0;
    end else if (msync < 2) msync++;
    else if (mph == 0) begin mir = prog[mpc]; mph = 1; end
    else begin model_exec(); mph = 0; end
  end

  // per-cycle comparison (R1 timing, R8 bus, R9/R10 program counter)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int op;
      bit es;
      op = int'(mir[3:0]);
      es = (mph == 1) && (op == 11 || op == 12);
      c_chk++;
      if (pc != 6'(mpc)) begin
        c_fail++; $display("FAIL R1/R9/R10 pc act=%0d exp=%0d", pc, mpc);
      end
      if (bus_stb != es) begin
        c_fail++; $display("FAIL R8 strobe act=%0b exp=%0b", bus_stb, es);
      end else if (es) begin
        if (bus_dir != (op == 12) || bus_addr != 4'(rdv(int'(mir[11:8])))) begin
          c_fail++; $display("FAIL R8 dir/addr act=%0b/%0h exp=%0b/%0h",
                             bus_dir, bus_addr, op == 12, rdv(int'(mir[11:8])));
        end else if (op == 12 && bus_wdata != 4'(rdv(int'(mir[7:4])))) begin
          c_fail++; $display("FAIL R8 wdata act=%0h exp=%0h", bus_wdata, rdv(int'(mir[7:4])));
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++; $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  function automatic logic [11:0] ins(input int op, input int a, input int b);
    return {4'(b), 4'(a), 4'(op)};
  endfunction

  function automatic logic [11:0] br(input int sel, input int tgt);
    return {2'(sel), 6'(tgt), 4'hD};
  endfunction

  task automatic fill(input int a, input int d);
    fill_en = 1'b1; fill_a = 4'(a); fill_d = 4'(d); tick(1); fill_en = 1'b0;
  endtask

  task automatic load_prog();
    for (int i = 0; i < 64; i++) begin
      pm_we = 1'b1; pm_waddr = 6'(i); pm_wdata = prog[i]; tick(1);
    end
    pm_we = 1'b0;
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 64; i++) prog[i] = 12'h00F;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures",
             n_chk + c_chk, n_fail + c_fail);
    $finish;
  endtask

  initial begin
    #1_500_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    done = 1'b1;
    summary();
  end

  initial begin
    tick(1);
    for (int i = 0; i < 16; i++) fill(i, 0);
    // program 1: arithmetic, shifts, logic, flags, R0, IN/OUT
    clear_prog();
    prog[0]  = ins(9, 1, 9);   prog[1]  = ins(9, 2, 8);
    prog[2]  = ins(0, 1, 2);   prog[3]  = ins(9, 3, 1);
    prog[4]  = ins(12, 1, 3);  prog[5]  = ins(9, 4, 0);
    prog[6]  = ins(0, 4, 4);   prog[7]  = ins(9, 3, 2);
    prog[8]  = ins(12, 4, 3);  prog[9]  = ins(9, 5, 3);
    prog[10] = ins(9, 6, 5);   prog[11] = ins(1, 5, 6);
    prog[12] = ins(9, 3, 3);   prog[13] = ins(12, 5, 3);
    prog[14] = ins(10, 7, 0);  prog[15] = ins(9, 3, 4);
    prog[16] = ins(12, 7, 3);  prog[17] = ins(9, 8, 10);
    prog[18] = ins(6, 8, 0);   prog[19] = ins(7, 8, 0);
    prog[20] = ins(9, 3, 5);   prog[21] = ins(12, 8, 3);
    prog[22] = ins(9, 9, 12);  prog[23] = ins(9, 10, 10);
    prog[24] = ins(2, 9, 10);  prog[25] = ins(5, 10, 9);
    prog[26] = ins(3, 9, 10);  prog[27] = ins(4, 10, 0);
    prog[28] = ins(9, 3, 6);   prog[29] = ins(12, 9, 3);
    prog[30] = ins(9, 3, 7);   prog[31] = ins(12, 10, 3);
    prog[32] = ins(8, 9, 9);   prog[33] = ins(10, 11, 0);
    prog[34] = ins(9, 3, 8);   prog[35] = ins(12, 11, 3);
    prog[36] = ins(9, 0, 0);   prog[37] = ins(11, 12, 3);
    prog[38] = ins(9, 3, 9);   prog[39] = ins(12, 12, 3);
    prog[40] = br(0, 40);
    load_prog();
    @(negedge clk);
    chk(pc == 0 && !bus_stb, "R11 idle in reset", pc, 0);
    tick(1); rst_n = 1'b1;
    tick(200);
    chk(periph[1] == 4'h1, "R3 ADD 9+8 low nibble", periph[1], 1);
    chk(periph[2] == 4'h1, "R3 carry chained into next ADD", periph[2], 1);
    chk(periph[3] == 4'hE, "R3 SUB borrow result", periph[3], 14);
    chk(periph[4] == 4'h5, "R7 R0 view after SUB", periph[4], 5);
    chk(periph[5] == 4'hA, "R4 SHL then SHR through carry", periph[5], 10);
    chk(periph[6] == 4'hA, "R5 AND/XOR/OR", periph[6], 10);
    chk(periph[7] == 4'hD, "R5 NOT", periph[7], 13);
    chk(periph[8] == 4'h3, "R6 CMP equal flags", periph[8], 3);
    chk(periph[9] == 4'h3, "R8 IN read back", periph[9], 3);
    chk(pc == 6'd40, "R9 JMP self loop", pc, 40);

    // program 2: branches and wrap
    rst_n = 1'b0;
    clear_prog();
    prog[0]  = ins(9, 1, 3);   prog[1]  = ins(9, 2, 1);
    prog[2]  = ins(9, 0, 0);   prog[3]  = ins(9, 3, 0);
    prog[4]  = ins(0, 3, 2);   prog[5]  = ins(1, 1, 2);
    prog[6]  = br(1, 4);       prog[7]  = ins(9, 4, 0);
    prog[8]  = ins(12, 3, 4);  prog[9]  = ins(9, 5, 2);
    prog[10] = ins(9, 6, 7);   prog[11] = ins(8, 5, 6);
    prog[12] = br(2, 14);      prog[13] = ins(12, 5, 4);
    prog[14] = ins(8, 6, 5);   prog[15] = br(2, 17);
    prog[16] = ins(9, 7, 6);   prog[17] = ins(9, 8, 1);
    prog[18] = ins(12, 7, 8);  prog[19] = br(3, 0);
    prog[20] = 12'h00E;        prog[21] = br(0, 62);
    prog[62] = ins(9, 9, 2);   prog[63] = ins(12, 9, 9);
    load_prog();
    for (int i = 0; i < 3; i++) fill(i, 15);
    rst_n = 1'b1;
    for (int i = 0; i < 400 && pc != 6'd63; i++) tick(1);
    chk(pc == 6'd63, "R9 JMP to word 62 reached 63", pc, 63);
    tick(2);
    chk(pc == 6'd0, "R10 wrap 63 to 0", pc, 0);
    chk(periph[0] == 4'h3, "R9 JNZ loop count / JLS taken", periph[0], 3);
    chk(periph[1] == 4'h6, "R9 JLS not taken", periph[1], 6);
    chk(periph[2] == 4'h2, "R10 words 62/63 executed", periph[2], 2);

    // rerun without reloading the program store
    rst_n = 1'b0;
    tick(2);
    for (int i = 0; i < 3; i++) fill(i, 15);
    rst_n = 1'b1;
    tick(120);
    chk(periph[0] == 4'h3, "R11 program kept over reset", periph[0], 3);
    chk(periph[1] == 4'h6, "R11 program kept over reset", periph[1], 6);

    // program 3: registers and flags cleared by reset
    rst_n = 1'b0;
    clear_prog();
    prog[0] = ins(9, 1, 12);  prog[1] = ins(12, 0, 1);
    prog[2] = ins(9, 1, 13);  prog[3] = ins(12, 7, 1);
    prog[4] = br(0, 4);
    load_prog();
    fill(12, 15); fill(13, 15);
    rst_n = 1'b1;
    tick(30);
    chk(periph[12] == 4'h0, "R11 flags cleared", periph[12], 0);
    chk(periph[13] == 4'h0, "R11 register cleared", periph[13], 0);
    chk(c_chk > 0, "R2 cycle compare ran", c_chk, 1);
    done = 1'b1;
    summary();
  end
endmodule